// File: doc/BRIEF.md
# Opcode-Configured Add/NAND Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for 16-bit two's-complement words. It takes two operands and a 4-bit opcode and returns one result word together with a zero flag and a negative flag. It has only two core functions: a wrapping ripple-carry addition and a bitwise NAND. Around that core, the opcode can flip every bit of either operand before the core function, and it can flip every bit of the core result afterwards.

With these three inversion controls, two core functions give a wide set of operations. Examples are AND, OR, NOR, subtraction, and adding with one operand complemented. For instance, inverting the first operand, adding, and then inverting the output gives the difference of the two operands. A decoder turns the opcode into a small set of control strobes. A datapath applies those strobes to the operands. The block holds no state, so the outputs follow the inputs within one combinational path.

Top module: `opcodeAlu`

## Requirements
- R1: When opcode[3] is 1, every bit of operand A is inverted before the core function. When it is 0, A is used unchanged.
- R2: When opcode[2] is 1, every bit of operand B is inverted before the core function. When it is 0, B is used unchanged.
- R3: When opcode[1] is 0, the core result is the sum of the two conditioned operands. The carry out of bit 15 is dropped, so the sum wraps modulo 65536.
- R4: When opcode[1] is 1, the core result is the bitwise NAND of the two conditioned operands.
- R5: When opcode[0] is 1, the final result is the bitwise inverse of the core result. When it is 0, the final result equals the core result.
- R6: Every inversion is bitwise and never arithmetic negation. For example, inverting 0x0001 gives 0xFFFE.
- R7: zeroFlag is 1 exactly when all 16 bits of the final result are 0.
- R8: negFlag always equals bit 15 of the final result.
- R9: Opcode 4'b1001 (invert A, add, invert output) yields A minus B modulo 65536.
- R10: The block has no clock or state. Its outputs depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| opcode | input | 4 | [3] invert A, [2] invert B, [1] 0=add 1=NAND, [0] invert result |
| result | output | 16 | Final result word |
| zeroFlag | output | 1 | High when result is all zeros |
| negFlag | output | 1 | Copy of result bit 15 |

## Verification
The block holds no state, so a fault is visible at the ports as soon as the inputs settle, and it lasts only while the faulty input pattern is applied. Each kind of fault shows up in a different way:
- A broken carry stage corrupts the sum only for operand pairs whose carries reach that stage. For this reason the vectors include long carry runs and wrap-around values.
- A swapped or stuck strobe shows up as a whole-word inversion, or as a NAND where a sum was expected. Stepping through all sixteen opcodes exposes it.
- A wrong flag shows up against the settled result of the same input set.

// File: rtl/opcode_alu_pkg.sv
package opcode_alu_pkg;
  localparam int DATA_W = 16;
  localparam int OPC_W  = 4;

  // bit positions of the opcode fields
  localparam int OPC_INV_A   = 3;
  localparam int OPC_INV_B   = 2;
  localparam int OPC_SEL_NAND = 1;
  localparam int OPC_INV_OUT = 0;

  typedef struct packed {
    logic invA;
    logic invB;
    logic selNand;
    logic invOut;
  } aluStrobes_t;
endpackage

// File: rtl/alu_half_adder.sv
module aluHalfAdder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/alu_full_adder.sv
module aluFullAdder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic partSum;
  logic carryLow;
  logic carryHigh;

  aluHalfAdder firstHalf (.x(x), .y(y), .s(partSum), .c(carryLow));
  aluHalfAdder secondHalf (.x(partSum), .y(cin), .s(s), .c(carryHigh));

  assign cout = carryLow | carryHigh;
endmodule

// File: rtl/alu_ripple_adder.sv
module aluRippleAdder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH:0] carryChain;
  logic unusedCarryOut;

  assign carryChain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : gStage
    aluFullAdder stage (
      .x   (x[i]),
      .y   (y[i]),
      .cin (carryChain[i]),
      .s   (sum[i]),
      .cout(carryChain[i+1])
    );
  end

  // carry beyond the top bit is dropped: sum wraps
  assign unusedCarryOut = carryChain[WIDTH];
endmodule

// File: rtl/alu_control.sv
module aluControl
  import opcode_alu_pkg::*;
#(
  parameter int OP_WIDTH = OPC_W
) (
  input  logic [OP_WIDTH-1:0] opcode,
  output aluStrobes_t         strobes
);
  always_comb begin
    strobes.invA    = opcode[OPC_INV_A];
    strobes.invB    = opcode[OPC_INV_B];
    strobes.selNand = opcode[OPC_SEL_NAND];
    strobes.invOut  = opcode[OPC_INV_OUT];
  end
endmodule

// File: rtl/alu_datapath.sv
module aluDatapath
  import opcode_alu_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] condA;
  logic [WIDTH-1:0] condB;
  logic [WIDTH-1:0] sumWord;
  logic [WIDTH-1:0] nandWord;
  logic [WIDTH-1:0] coreWord;

  // operand conditioning: XOR with a replicated strobe flips every bit
  assign condA = opA ^ (strobes.invA ? ALL_ONES : '0);
  assign condB = opB ^ (strobes.invB ? ALL_ONES : '0);

  aluRippleAdder #(.WIDTH(WIDTH)) adder (
    .x  (condA),
    .y  (condB),
    .sum(sumWord)
  );

  assign nandWord = ~(condA & condB);

  // 2:1 select, 0 passes the adder
  assign coreWord = strobes.selNand ? nandWord : sumWord;

  assign result   = coreWord ^ (strobes.invOut ? ALL_ONES : '0);
  assign zeroFlag = ~|result;
  assign negFlag  = result[WIDTH-1];
endmodule

// File: rtl/opcode_alu.sv
module opcodeAlu
  import opcode_alu_pkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [3:0]  opcode,
  output logic [15:0] result,
  output logic        zeroFlag,
  output logic        negFlag
);
  aluStrobes_t strobes;

  aluControl #(.OP_WIDTH(OPC_W)) ctrl (
    .opcode (opcode),
    .strobes(strobes)
  );

  aluDatapath #(.WIDTH(DATA_W)) dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .zeroFlag(zeroFlag),
    .negFlag (negFlag)
  );
endmodule

// File: rtl/opcode_alu_checker.sv
module opcodeAluChecker (
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [3:0]  opcode,
  input logic [15:0] result,
  input logic        zeroFlag,
  input logic        negFlag
);
  logic [15:0] wrapSum;
  logic [15:0] diff;
  assign wrapSum = opA + opB;
  assign diff    = opA - opB;

  always_comb begin
    if (opcode == 4'b0000) begin
      assert_plain_add_R3: assert (result == wrapSum);
    end
    if (opcode == 4'b0010) begin
      assert_plain_nand_R4: assert (result == ~(opA & opB));
    end
    if (opcode == 4'b1001) begin
      assert_subtract_R9: assert (result == diff);
    end
    if (opcode == 4'b0011) begin
      assert_and_via_inv_R5: assert (result == (opA & opB));
    end
    if (zeroFlag) begin
      assert_zero_flag_R7: assert (result == 16'h0000);
    end
    if (negFlag) begin
      assert_neg_flag_R8: assert (result[15]);
    end
  end
endmodule

bind opcodeAlu opcodeAluChecker chk (
  .opA     (opA),
  .opB     (opB),
  .opcode  (opcode),
  .result  (result),
  .zeroFlag(zeroFlag),
  .negFlag (negFlag)
);

// File: tb/opcode_alu_test.sv
module opcodeAlu_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [15:0] opA;
  logic [15:0] opB;
  logic [3:0]  opcode;
  logic [15:0] result;
  logic        zeroFlag;
  logic        negFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  opcodeAlu uut (
    .opA(opA), .opB(opB), .opcode(opcode),
    .result(result), .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  // {opcode, A, B, expected}
  localparam int NVEC = 11;
  localparam logic [51:0] VECS [NVEC] = '{
    {4'b0000, 16'h0001, 16'h0001, 16'h0002},  // R3
    {4'b0000, 16'hFFFF, 16'h0001, 16'h0000},  // R3 wrap, R7
    {4'b0010, 16'hF0F0, 16'hFF00, 16'h0FFF},  // R4
    {4'b1000, 16'h0001, 16'h0000, 16'hFFFE},  // R1, R6
    {4'b0100, 16'h0000, 16'h00FF, 16'hFF00},  // R2
    {4'b0001, 16'h1234, 16'h0000, 16'hEDCB},  // R5
    {4'b1001, 16'h0005, 16'h0003, 16'h0002},  // R9
    {4'b1001, 16'h0003, 16'h0005, 16'hFFFE},  // R9 negative
    {4'b0110, 16'h00FF, 16'h0F0F, 16'hFF0F},  // R2, R4
    {4'b1110, 16'hAAAA, 16'h5555, 16'hFFFF},  // R1, R2, R4
    {4'b0000, 16'h7FFF, 16'h0001, 16'h8000}   // R3, R8
  };

  function automatic logic [15:0] refModel(input logic [3:0] op,
                                           input logic [15:0] a,
                                           input logic [15:0] b);
    logic [15:0] ca, cb, core;
    ca = op[3] ? ~a : a;
    cb = op[2] ? ~b : b;
    core = op[1] ? ~(ca & cb) : 16'((32'(ca) + 32'(cb)) % 32'd65536);
    return op[0] ? ~core : core;
  endfunction

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
               tag, opcode, opA, opB, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b);
    @(posedge clk);
    opcode = op; opA = a; opB = b;
    @(negedge clk);
  endtask

  task automatic checkFlags();
    check("R7 zeroFlag", {15'd0, zeroFlag}, {15'd0, result == 16'h0000});
    check("R8 negFlag", {15'd0, negFlag}, {15'd0, result[15]});
  endtask

  initial begin
    opcode = 4'b0000; opA = '0; opB = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // initial state: all-zero inputs, R10 no clock needed
    check("R10 idle result", result, 16'h0000);
    check("R7 idle zero", {15'd0, zeroFlag}, 16'h0001);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][51:48], VECS[i][47:32], VECS[i][31:16]);
      check("R1-table", result, VECS[i][15:0]);
      checkFlags();
    end

    // directed: R6 bitwise inversion of 1 is 0xFFFE not 0xFFFF
    apply(4'b1000, 16'h0001, 16'h0000);
    check("R6 bitwise invert", result, 16'hFFFE);
    // R8 negative flag on wrapped subtract
    apply(4'b1001, 16'h0000, 16'h0001);
    check("R9 zero minus one", result, 16'hFFFF);
    check("R8 neg set", {15'd0, negFlag}, 16'h0001);
    // R10: changing inputs between edges still settles
    opA = 16'h0010; opB = 16'h0020; opcode = 4'b0000;
    #1;
    check("R10 settle midcycle", result, 16'h0030);

    // every opcode with random operands (R1..R5, R9)
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (n % 7 == 0) ra = 16'hFFFF;
      if (n % 11 == 0) rb = 16'h8000;
      apply(4'(n % 16), ra, rb);
      check("R1 R2 R3 R4 R5 random", result, refModel(4'(n % 16), ra, rb));
      if (n % 16 == 9) check("R9 random subtract", result, 16'(ra - rb));
      checkFlags();
    end
    done = 1'b1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule